// File: doc/BRIEF.md
# SIMD Element Reverse Unit

This block decodes a single 32-bit SIMD "reverse elements" instruction word and computes its result in one pass. The source vector is 64 or 128 bits wide. It is divided into regions of 16, 32 or 64 bits, and the order of the 8-, 16- or 32-bit elements inside each region is reversed. Bytes keep their order inside an element.

The block checks the word's fixed bits and rejects illegal size pairings. In the 128-bit form it also rejects odd register numbers. It returns a registered result, a destination register number and an undefined-instruction flag one clock after a valid input.

The register file sits outside the block and supplies the source vector. The register file also consumes the outputs.

Top module: `simd_rev_unit`

## Requirements
- R1: An instruction matches only when bits 31:23 = 111100111, bits 21:20 = 11, bits 17:16 = 00, bits 11:9 = 000 and bit 4 = 0. A valid word that does not match raises `undef_o` and keeps `valid_o` low.
- R2: The size field is bits 19:18, where value s means elements of 8<<s bits. The operation field is bits 8:7, where 00, 01 and 10 mean regions of 64, 32 and 16 bits. When operation plus size is 3 or more, `undef_o` is raised and `valid_o` stays low.
- R3: When bit 6 (Q) is 1, the instruction is the 128-bit form. In that form, if bit 12 (lowest bit of the destination field) or bit 0 (lowest bit of the source field) is 1, `undef_o` is raised and `valid_o` stays low.
- R4: `dst_idx_o` equals {bit 22, bits 15:12} of the accepted instruction.
- R5: With 64-bit regions, the order of the 8-, 16- or 32-bit elements in each region is reversed.
- R6: With 32-bit regions, the order of the 8- or 16-bit elements in each region is reversed.
- R7: With 16-bit regions, the two bytes of every halfword are swapped.
- R8: When Q is 0, only the low 64 bits of the source are used, and `result_o[127:64]` is zero.
- R9: Outputs are registered one clock after `valid_i`, and `valid_o` and `undef_o` are never high together. A cycle without `valid_i` produces neither flag. `result_o` and `dst_idx_o` change only on an accepted legal instruction and otherwise keep their values.
- R10: Active-low asynchronous reset `rst_ni` clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction and source are presented |
| insn_i | input | 32 | Instruction word |
| src_i | input | 128 | Source vector (low 64 bits in the 64-bit form) |
| valid_o | output | 1 | Legal instruction completed; result is written |
| undef_o | output | 1 | Instruction was undefined; no write |
| dst_idx_o | output | 5 | Destination 64-bit register number |
| result_o | output | 128 | Reversed vector |

## Verification
The bench walks every legal pairing of element and region size in both widths with a byte-ramp source. A wrong permutation therefore shows up as misplaced bytes rather than as a value that could pass by chance.

It also drives the boundary pairings where operation plus size reaches exactly 3, and the reserved operation value 11. A design that compared against 4, or that ignored the top operation code, would raise `valid_o` for these words.

Odd register fields are driven in the 128-bit form and also in the 64-bit form, where they are legal. A design that applied the odd-register check regardless of Q would reject good instructions.

Illegal words are followed by a check that the result and the index held their values. Each fixed bit is flipped in turn. Random legal and mutated words are then compared against a behavioural model on every clock.

// File: rtl/simd_rev_pkg.sv
package simd_rev_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned IDX_W  = 5;

  // fixed-bit mask/value of the reverse instruction pattern
  localparam logic [INSN_W-1:0] FIX_MASK = 32'hFFB3_0E10;
  localparam logic [INSN_W-1:0] FIX_VAL  = 32'hF3B0_0000;

  typedef enum logic [1:0] {
    REGION_64 = 2'b00,
    REGION_32 = 2'b01,
    REGION_16 = 2'b10,
    REGION_NA = 2'b11
  } region_e;

  typedef struct packed {
    logic             legal;
    logic             wide;
    region_e          region;
    logic [1:0]       esize;
    logic [IDX_W-1:0] dst_idx;
  } rev_dec_t;
endpackage

// File: rtl/simd_rev_decode.sv
module simd_rev_decode
  import simd_rev_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output rev_dec_t          dec_o
);
  logic       fix_ok;
  logic       size_ok;
  logic       pair_ok;
  logic [2:0] size_sum;

  assign fix_ok   = (insn_i & FIX_MASK) == FIX_VAL;
  assign size_sum = {1'b0, insn_i[8:7]} + {1'b0, insn_i[19:18]};
  assign size_ok  = size_sum < 3'd3;
  // 128-bit form names register pairs: both fields must be even
  assign pair_ok  = !insn_i[6] || !(insn_i[12] || insn_i[0]);

  always_comb begin
    dec_o.legal   = fix_ok && size_ok && pair_ok;
    dec_o.wide    = insn_i[6];
    dec_o.region  = region_e'(insn_i[8:7]);
    dec_o.esize   = insn_i[19:18];
    dec_o.dst_idx = {insn_i[22], insn_i[15:12]};
  end
endmodule

// File: rtl/simd_rev_perm.sv
module simd_rev_perm
  import simd_rev_pkg::*;
#(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [VEC_W-1:0] src_i,
  input  region_e          region_i,
  input  logic [1:0]       esize_i,
  input  logic             wide_i,
  output logic [VEC_W-1:0] result_o
);
  localparam int unsigned NB    = VEC_W / BYTE_W;
  localparam int unsigned HALF  = NB / 2;
  localparam int unsigned SEL_W = $clog2(NB);

  // reversing element order inside a power-of-two region flips the
  // element-index bits of the byte address
  logic [SEL_W-1:0] flip;

  always_comb begin
    flip = SEL_W'((32'd8 >> region_i) - 32'd1) & ~SEL_W'((32'd1 << esize_i) - 32'd1);
  end

  for (genvar j = 0; j < NB; j++) begin : g_byte
    logic [SEL_W-1:0] sel;
    assign sel = SEL_W'(j) ^ flip;
    if (j >= HALF) begin : g_hi
      assign result_o[j*BYTE_W +: BYTE_W] = wide_i ? src_i[int'(sel)*BYTE_W +: BYTE_W] : '0;
    end else begin : g_lo
      assign result_o[j*BYTE_W +: BYTE_W] = src_i[int'(sel)*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/simd_rev_unit.sv
module simd_rev_unit
  import simd_rev_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSN_W-1:0]  insn_i,
  input  logic [VEC_W-1:0]   src_i,
  output logic               valid_o,
  output logic               undef_o,
  output logic [IDX_W-1:0]   dst_idx_o,
  output logic [VEC_W-1:0]   result_o
);
  rev_dec_t         dec;
  logic [VEC_W-1:0] perm;
  logic             accept;

  simd_rev_decode i_decode (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  simd_rev_perm #(.VEC_W(VEC_W)) i_perm (
    .src_i    (src_i),
    .region_i (dec.region),
    .esize_i  (dec.esize),
    .wide_i   (dec.wide),
    .result_o (perm)
  );

  assign accept = valid_i && dec.legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      undef_o   <= 1'b0;
      dst_idx_o <= '0;
      result_o  <= '0;
    end else begin
      valid_o <= accept;
      undef_o <= valid_i && !dec.legal;
      if (accept) begin
        dst_idx_o <= dec.dst_idx;
        result_o  <= perm;
      end
    end
  end

  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && undef_o));
  assert_resp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || undef_o) |-> $past(valid_i));
  assert_size_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (({1'b0, $past(insn_i[8:7])} + {1'b0, $past(insn_i[19:18])}) < 3'd3));
  assert_even_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(insn_i[6])) |-> !dst_idx_o[0]);
  assert_hi_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(insn_i[6])) |-> (result_o[VEC_W-1:VEC_W/2] == '0));
  assert_ones_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(insn_i[6])) |-> ($countones(result_o) == $past($countones(src_i))));
endmodule

// File: tb/test_simd_rev_unit.sv
`timescale 1ns/1ps
module test_simd_rev_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [31:0]  insn_i = '0;
  logic [127:0] src_i = '0;
  logic         valid_o, undef_o;
  logic [4:0]   dst_idx_o;
  logic [127:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic         exp_valid = 0, exp_undef = 0;
  logic [4:0]   exp_dst = '0;
  logic [127:0] exp_res = '0;
  string        tag_flag = "R10", tag_res = "R10";

  always #2.5 clk_i = ~clk_i;

  simd_rev_unit i_simd_rev_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
    .src_i(src_i), .valid_o(valid_o), .undef_o(undef_o),
    .dst_idx_o(dst_idx_o), .result_o(result_o)
  );

  function automatic logic [31:0] mk(bit d, int sz, int dd, int op, bit q, bit m, int mm);
    return {9'b111100111, d, 2'b11, 2'(sz), 2'b00, 4'(dd), 3'b000, 2'(op), q, m, 1'b0, 4'(mm)};
  endfunction

  function automatic logic [127:0] ref_rev(logic [127:0] s, int op, int sz, bit q);
    logic [127:0] o = '0;
    int rb = 8 >> op;
    int eb = 1 << sz;
    int nb = q ? 16 : 8;
    for (int r = 0; r < nb; r += rb)
      for (int e = 0; e < rb / eb; e++)
        for (int k = 0; k < eb; k++)
          o[(r + (rb/eb - 1 - e)*eb + k)*8 +: 8] = s[(r + e*eb + k)*8 +: 8];
    return o;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(valid_o === exp_valid, tag_flag, "valid_o", 128'(valid_o), 128'(exp_valid));
    chk(undef_o === exp_undef, tag_flag, "undef_o", 128'(undef_o), 128'(exp_undef));
    chk(dst_idx_o === exp_dst, "R4", "dst_idx_o", 128'(dst_idx_o), 128'(exp_dst));
    chk(result_o === exp_res, tag_res, "result_o", result_o, exp_res);
  endtask

  // drive one cycle at the falling edge; the previous cycle's outputs are checked first
  task automatic step(bit v, logic [31:0] w, logic [127:0] s);
    bit fix_ok, size_ok, pair_ok, legal;
    int op, sz;
    @(negedge clk_i);
    compare();
    valid_i = v; insn_i = w; src_i = s;
    op = int'(w[8:7]); sz = int'(w[19:18]);
    fix_ok  = (w[31:23] == 9'b111100111) && (w[21:20] == 2'b11) &&
              (w[17:16] == 2'b00) && (w[11:9] == 3'b000) && !w[4];
    size_ok = (op + sz) < 3;
    pair_ok = !(w[6] && (w[12] || w[0]));
    legal   = fix_ok && size_ok && pair_ok;
    exp_valid = v && legal;
    exp_undef = v && !legal;
    if (!v) tag_flag = "R9";
    else if (!fix_ok) tag_flag = "R1";
    else if (!size_ok) tag_flag = "R2";
    else if (!pair_ok) tag_flag = "R3";
    else tag_flag = "R9";
    if (v && legal) begin
      exp_dst = {w[22], w[15:12]};
      exp_res = ref_rev(s, op, sz, w[6]);
      tag_res = !w[6] ? "R8" : (op == 0) ? "R5" : (op == 1) ? "R6" : "R7";
    end else begin
      tag_res = "R9";
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] ramp;
    for (int i = 0; i < 16; i++) ramp[i*8 +: 8] = 8'(i);

    // reset state (R10)
    @(negedge clk_i);
    chk(valid_o === 0 && undef_o === 0, "R10", "flags in reset", 128'({valid_o, undef_o}), 0);
    chk(result_o === '0 && dst_idx_o === '0, "R10", "data in reset", result_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    step(0, '0, '0);  // idle: no flags (R9)
    // every legal pairing, both widths (R5 R6 R7 R8)
    for (int q = 0; q < 2; q++)
      for (int op = 0; op < 3; op++)
        for (int sz = 0; sz + op < 3; sz++)
          step(1, mk(1'(op), sz, 2*op + 4, op, 1'(q), 1'(sz), 2), ramp);
    // known values: 16-bit regions swap halfword bytes (R7)
    step(1, mk(0, 0, 2, 2, 1, 0, 0), 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff);
    // illegal pairings: sum of 3, reserved op (R2) followed by hold (R9)
    step(1, mk(0, 1, 0, 2, 0, 0, 0), ramp);
    step(1, mk(0, 2, 0, 1, 0, 0, 0), ramp);
    step(1, mk(0, 3, 0, 0, 1, 0, 0), ramp);
    step(1, mk(0, 0, 0, 3, 0, 0, 0), ramp);
    step(0, '0, '0);
    // odd registers: illegal in 128-bit form (R3), legal in 64-bit form
    step(1, mk(0, 0, 3, 0, 1, 0, 2), ramp);
    step(1, mk(0, 0, 2, 0, 1, 0, 5), ramp);
    step(1, mk(1, 1, 7, 1, 0, 1, 9), ~ramp);
    // each fixed bit flipped (R1)
    for (int b = 0; b < 32; b++) begin
      logic [31:0] w = mk(0, 0, 0, 0, 0, 0, 0);
      if (b >= 23 || b == 20 || b == 21 || b == 16 || b == 17 ||
          (b >= 9 && b <= 11) || b == 4)
        step(1, w ^ (32'd1 << b), ramp);
    end
    // random legal and mutated words
    for (int n = 0; n < 3000; n++) begin
      logic [31:0]  w;
      logic [127:0] s = {$urandom, $urandom, $urandom, $urandom};
      w = mk(1'($urandom), int'($urandom % 3), int'($urandom % 16), int'($urandom % 3),
             1'($urandom), 1'($urandom), int'($urandom % 16));
      if ($urandom % 8 == 0) w = w ^ (32'd1 << ($urandom % 32));
      step(1'($urandom % 4 != 0), w, s);
    end
    // reset in mid-run (R10)
    step(1, mk(0, 0, 4, 0, 1, 0, 0), ramp);
    @(negedge clk_i);
    compare();
    rst_ni = 1'b0; valid_i = 1'b0;
    #1;
    chk(valid_o === 0 && undef_o === 0 && result_o === '0 && dst_idx_o === '0,
        "R10", "async clear", result_o, 0);
    exp_valid = 0; exp_undef = 0; exp_res = '0; exp_dst = '0; tag_flag = "R10"; tag_res = "R10";
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, '0, '0);
    step(0, '0, '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule